// File: doc/BRIEF.md
# Wraparound-Safe Compare Event Timer

This block is a timer built around one free-running up-counter and one compare channel. Software schedules an event by reading the live count and writing that count plus a delay into the compare register. The channel raises its event when the counter has reached or gone past the programmed value. Wraparound is taken into account, so a compare value written a little too late fires at once instead of a full counter wrap later. A periodic mode uses a reload value as the top of the count, and that reload value can be buffered until the next wrap.

Control goes through a plain register bus: a one-cycle write strobe with a word address, and combinational read data. This bus has no valid/ready handshake. Every write is accepted in the cycle it is presented, and a read returns the live state in the same cycle, so there is no back-pressure to manage. Two sticky status flags are cleared by writing 1 to them. They drive a single interrupt output through per-flag enables.

Register words: 0 control (bit0 count enable, bit1 reload buffering, bit2 periodic), 1 count, 2 reload, 3 compare, 4 interrupt enable (bit0 compare, bit1 wrap), 5 status (bit0 compare hit, bit1 wrap).

Top module: `cmp_event_timer`

## Requirements
- R1: After reset, control, count, compare, interrupt enable and status all read 0, reload reads all-ones, and irq is low.
- R2: While control bit0 is 1 the counter adds one on every clock edge; while it is 0 the counter holds. Reading word 1 returns the current count with no added delay, and writing word 1 loads the count.
- R3: With control bit2 clear, the counter steps from all-ones to zero and sets status bit1 on that step.
- R4: An armed compare hits when (count minus compare) modulo 2^32 has bit 31 equal to 0. A hit sets status bit1's neighbour, status bit0, on the next clock edge.
- R5: For a running counter, status bit0 becomes set on the clock edge that follows the edge at which the count became equal to the compare value.
- R6: Writing word 3 arms the channel. The first hit disarms it, so the same compare value does not set status bit0 again.
- R7: A compare write in the same cycle as a hit keeps that hit, arms the new value, and the new value then fires exactly once.
- R8: Writing 1 to a status bit clears it. Writing 0 to it leaves it unchanged.
- R9: irq is high exactly when some status bit and its interrupt enable bit (word 4) are both 1.
- R10: With control bit2 set, the counter steps from the active reload value to zero and sets status bit1 on that step.
- R11: With control bit1 clear, a reload write takes effect at once. With it set, the written value becomes active only at the next wrap. Word 2 reads back the last written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arm flag or a wrong compare value shows at the ports one edge late. Either status bit0 fails to rise on the edge after the count matches, or it rises again after being cleared. A wrong subtraction sign shows up as a missed or spurious hit for compare values just behind or far ahead of the count, and the wraparound vectors catch this on the second edge after arming. A wrong active reload appears in the count readback within one period, as a wrap at the wrong value.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    RW_CTRL   = 3'd0,
    RW_COUNT  = 3'd1,
    RW_RELOAD = 3'd2,
    RW_CMP    = 3'd3,
    RW_IEN    = 3'd4,
    RW_STAT   = 3'd5
  } reg_word_t;

  localparam int CTL_EN       = 0;
  localparam int CTL_BUFFERED = 1;
  localparam int CTL_PERIODIC = 2;
  localparam int CTL_W        = 3;

  localparam int EV_HIT  = 0;
  localparam int EV_WRAP = 1;
  localparam int EV_W    = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             periodic,
  input  logic             buffered,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rel_wr,
  input  logic [CNT_W-1:0] rel_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rel_shadow,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] rel_active;
  logic [CNT_W-1:0] top;

  assign top  = periodic ? rel_active : ALL_ONES;
  assign wrap = run && !load && (count == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (wrap) begin
      count <= '0;
    end else if (run) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_shadow <= ALL_ONES;
      rel_active <= ALL_ONES;
    end else begin
      if (rel_wr) rel_shadow <= rel_val;
      if (rel_wr && !buffered) rel_active <= rel_val;
      else if (wrap && buffered) rel_active <= rel_shadow;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !wrap) |=> (count == $past(count) + 1'b1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             arm_wr,
  input  logic [CNT_W-1:0] arm_val,
  output logic [CNT_W-1:0] cmp_val,
  output logic             hit
);
  logic             armed;
  logic [CNT_W-1:0] diff;

  assign diff = count - cmp_val;
  assign hit  = armed && !diff[CNT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
      armed   <= 1'b0;
    end else if (arm_wr) begin
      cmp_val <= arm_val;
      armed   <= 1'b1;
    end else if (hit) begin
      armed   <= 1'b0;
    end
  end

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !arm_wr) |=> !hit);
  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> (cmp_val == $past(arm_val)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  rel_shadow,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic              hit,
  input  logic              wrap,
  output logic              run,
  output logic              buffered,
  output logic              periodic,
  output logic              cnt_load,
  output logic              rel_wr,
  output logic              cmp_wr,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [CTL_W-1:0] ctrl;
  logic [EV_W-1:0]  ien;
  logic [EV_W-1:0]  stat;
  logic [EV_W-1:0]  ev_set;
  logic [EV_W-1:0]  ev_clr;
  reg_word_t        word;

  assign word     = reg_word_t'(bus_addr);
  assign run      = ctrl[CTL_EN];
  assign buffered = ctrl[CTL_BUFFERED];
  assign periodic = ctrl[CTL_PERIODIC];
  assign cnt_load = bus_wr && (word == RW_COUNT);
  assign rel_wr   = bus_wr && (word == RW_RELOAD);
  assign cmp_wr   = bus_wr && (word == RW_CMP);

  always_comb begin
    ev_set          = '0;
    ev_set[EV_HIT]  = hit;
    ev_set[EV_WRAP] = wrap;
    ev_clr = (bus_wr && (word == RW_STAT)) ? bus_wdata[EV_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      ien  <= '0;
      stat <= '0;
    end else begin
      if (bus_wr && (word == RW_CTRL)) ctrl <= bus_wdata[CTL_W-1:0];
      if (bus_wr && (word == RW_IEN))  ien  <= bus_wdata[EV_W-1:0];
      stat <= (stat & ~ev_clr) | ev_set;
    end
  end

  assign irq = |(stat & ien);

  always_comb begin
    bus_rdata = '0;
    case (word)
      RW_CTRL:   bus_rdata[CTL_W-1:0] = ctrl;
      RW_COUNT:  bus_rdata = count;
      RW_RELOAD: bus_rdata = rel_shadow;
      RW_CMP:    bus_rdata = cmp_val;
      RW_IEN:    bus_rdata[EV_W-1:0] = ien;
      RW_STAT:   bus_rdata[EV_W-1:0] = stat;
      default:   bus_rdata = '0;
    endcase
  end

  assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat[EV_HIT]);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[EV_HIT] && !ev_clr[EV_HIT]) |=> stat[EV_HIT]);
  assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> stat[EV_WRAP]);
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             run, buffered, periodic;
  logic             cnt_load, rel_wr, cmp_wr;
  logic             hit, wrap;
  logic [CNT_W-1:0] count, rel_shadow, cmp_val;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count), .rel_shadow(rel_shadow),
    .cmp_val(cmp_val), .hit(hit), .wrap(wrap), .run(run),
    .buffered(buffered), .periodic(periodic), .cnt_load(cnt_load),
    .rel_wr(rel_wr), .cmp_wr(cmp_wr), .bus_rdata(bus_rdata), .irq(irq)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .periodic(periodic),
    .buffered(buffered), .load(cnt_load), .load_val(bus_wdata),
    .rel_wr(rel_wr), .rel_val(bus_wdata), .count(count),
    .rel_shadow(rel_shadow), .wrap(wrap)
  );

  tmr_compare #(.CNT_W(CNT_W)) u_compare (
    .clk(clk), .rst_n(rst_n), .count(count), .arm_wr(cmp_wr),
    .arm_val(bus_wdata), .cmp_val(cmp_val), .hit(hit)
  );

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit) || $past(wrap) || $past(bus_wr)));
endmodule

// File: tb/test_cmp_event_timer.sv
module test_cmp_event_timer;
  localparam int A_CTRL = 0, A_CNT = 1, A_REL = 2, A_CMP = 3, A_IEN = 4, A_STAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cmp_event_timer i_cmp_event_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {count, compare, expected hit}
  localparam logic [64:0] VEC [6] = '{
    {32'd10,         32'd10,         1'b1},
    {32'd10,         32'd11,         1'b0},
    {32'h0000_0005,  32'hFFFF_FFF0,  1'b1},
    {32'hFFFF_FFF0,  32'h0000_0005,  1'b0},
    {32'h8000_1233,  32'h0000_1234,  1'b1},
    {32'h8000_1234,  32'h0000_1234,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = a[2:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = a[2:0];
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_REL, v);  check("R1 reload", v, 32'hFFFF_FFFF);
    rd(A_CMP, v);  check("R1 cmp", v, 0);
    rd(A_IEN, v);  check("R1 ien", v, 0);
    rd(A_STAT, v); check("R1 stat", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R4 vector table, counter stopped
    for (int i = 0; i < 6; i++) begin
      wr(A_CTRL, 0);
      wr(A_CNT, VEC[i][64:33]);
      wr(A_CMP, VEC[i][64:33] + 32'h4000_0000);
      wr(A_STAT, 3);
      wr(A_CMP, VEC[i][32:1]);
      wait_cyc(2);
      rd(A_STAT, v);
      check($sformatf("R4 vector %0d", i), {31'd0, v[0]}, {31'd0, VEC[i][0]});
    end

    // R5 / R2 / R9 exact hit timing with running counter
    wr(A_CTRL, 0);
    wr(A_CNT, 1000);
    wr(A_CMP, 32'h4000_0000);
    wr(A_STAT, 3);
    wr(A_CMP, 1010);
    wr(A_IEN, 1);
    wr(A_CTRL, 1);
    rd(A_CNT, v);  check("R2 count held before run", v, 1000);
    wait_cyc(5);
    rd(A_CNT, v);  check("R2 count live", v, 1005);
    wait_cyc(5);
    rd(A_CNT, v);  check("R5 count at match", v, 1010);
    rd(A_STAT, v); check("R5 no flag yet", v, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    wait_cyc(1);
    rd(A_STAT, v); check("R5 flag after match", v, 1);
    check("R9 irq high", {31'd0, irq}, 1);
    wr(A_IEN, 0);
    check("R9 irq masked", {31'd0, irq}, 0);
    wr(A_STAT, 0);
    rd(A_STAT, v); check("R8 write 0 keeps", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R8 write 1 clears", v, 0);
    wait_cyc(20);
    rd(A_STAT, v); check("R6 no refire", v, 0);

    // R7 compare write coinciding with a hit
    wr(A_CNT, 2000);
    wr(A_CMP, 2005);
    wait_cyc(4);
    wr(A_CMP, 2010);
    rd(A_STAT, v); check("R7 old hit kept", v, 1);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R7 cleared", v, 0);
    wait_cyc(3);
    rd(A_STAT, v); check("R7 new not early", v, 0);
    wait_cyc(1);
    rd(A_STAT, v); check("R7 new fired", v, 1);
    wr(A_STAT, 1);
    wait_cyc(10);
    rd(A_STAT, v); check("R7 fired once", v, 0);

    // R3 free-running wrap
    wr(A_CTRL, 0);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_STAT, 3);
    wr(A_CTRL, 1);
    wait_cyc(1);
    rd(A_CNT, v);  check("R3 at all-ones", v, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R3 no wrap yet", {31'd0, v[1]}, 0);
    wait_cyc(1);
    rd(A_CNT, v);  check("R3 wrapped", v, 0);
    rd(A_STAT, v); check("R3 wrap flag", {31'd0, v[1]}, 1);

    // R10 / R11 periodic, immediate reload
    wr(A_CTRL, 0);
    wr(A_REL, 9);
    wr(A_CNT, 0);
    wr(A_STAT, 3);
    wr(A_CTRL, 5);
    wait_cyc(9);
    rd(A_CNT, v);  check("R10 at reload", v, 9);
    rd(A_STAT, v); check("R10 no wrap yet", {31'd0, v[1]}, 0);
    wait_cyc(1);
    rd(A_CNT, v);  check("R10 wrap to zero", v, 0);
    rd(A_STAT, v); check("R10 wrap flag", {31'd0, v[1]}, 1);

    // R11 buffered reload
    wr(A_CTRL, 6);
    wr(A_CNT, 0);
    wr(A_REL, 4);
    rd(A_REL, v);  check("R11 readback", v, 4);
    wr(A_CTRL, 7);
    wait_cyc(5);
    rd(A_CNT, v);  check("R11 old period kept", v, 5);
    wait_cyc(5);
    rd(A_CNT, v);  check("R11 wrap at old", v, 0);
    wait_cyc(4);
    rd(A_CNT, v);  check("R11 new top", v, 4);
    wait_cyc(1);
    rd(A_CNT, v);  check("R11 wrap at new", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule